// File: doc/BRIEF.md
# Receive Ring Frame Writer

This block takes one received frame at a time and stores it in host memory through a 16-entry receive descriptor ring. A frame arrives as a header carrying its byte count, followed by exactly that many payload bytes on a byte stream. The block starts at its ring pointer and probes the status byte of each descriptor to find one that software has handed over. It writes the message-length field into the chosen descriptor, copies the payload into that entry's buffer slot, and then writes a completion status that gives the descriptor back to software. Host memory is reached through a byte-wide request port with one cycle of read latency.

When the block claims an entry, it raises a one-cycle receive-done pulse. This pulse feeds the receive-done and interrupt-summary flags of the controller's status register. In the same cycle it raises an interrupt request if interrupts are enabled. A frame that finds no usable descriptor is drained from the stream and reported on a drop pulse. A frame that arrives while the controller is stopped is drained with no memory traffic at all.

Top module: `rxring_writer`

## Requirements
- R1: After reset the ring pointer is 0, there is no memory request, the header input is ready, and the done, interrupt and drop pulses are low.
- R2: Descriptor i sits at desc_base + 8*i. Its status byte is at offset 2, and the entry is claimed only when that byte equals exactly 0x80. Any other value, including 0x80 with other bits set, makes the block skip the entry.
- R3: Probing starts at the ring pointer and goes upward modulo 16, one status read per entry. It stops at the first usable entry and covers at most 15 entries, so the entry just below the pointer is never probed.
- R4: For a claimed entry, the block first writes the 16-bit length, equal to the stored byte count plus 4, into the descriptor in swapped byte order. The high byte goes to offset 6 and the low byte to offset 7.
- R5: Payload byte k is written to buf_base + 1544*slot + k, in stream order.
- R6: Only the first 1544 bytes of a longer frame are stored. The remaining bytes are still consumed from the stream, and the length field reports 1544 + 4.
- R7: After the payload, the block writes 0x03 (start and end of packet, ownership cleared) to the claimed entry's status byte.
- R8: Each stored frame advances the ring pointer by exactly one, modulo 16. The step is from the pointer's old value, whichever entry took the frame. No other event moves the pointer.
- R9: Each stored frame gives exactly one done pulse. It gives one interrupt pulse in the same cycle when interrupt enable is high, and none when it is low.
- R10: A frame whose header is accepted while stop is high causes no memory access, no pulse and no pointer change, and its payload is consumed.
- R11: When no probed entry is usable, the block pulses drop once, writes nothing, leaves the pointer unchanged and consumes the payload.
- R12: A zero-length frame that finds a usable entry writes a length of 4 and the 0x03 status, with no payload writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Controller stopped; sampled when a header is accepted |
| int_en_i | input | 1 | Interrupt enable |
| desc_base_i | input | 24 | Byte address of descriptor 0 |
| buf_base_i | input | 24 | Byte address of buffer slot 0 |
| hdr_valid_i | input | 1 | Frame header valid |
| hdr_len_i | input | 11 | Frame length in bytes |
| hdr_ready_o | output | 1 | Header accepted when high with valid |
| dat_valid_i | input | 1 | Payload byte valid |
| dat_byte_i | input | 8 | Payload byte |
| dat_ready_o | output | 1 | Payload byte accepted when high with valid |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | 24 | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after a read request |
| ring_ptr_o | output | 4 | Current ring pointer |
| rx_done_o | output | 1 | One-cycle pulse per stored frame |
| irq_o | output | 1 | Interrupt request pulse |
| drop_o | output | 1 | One-cycle pulse when no descriptor was found |

## Verification
The assertions take three things for granted. The header length stays steady while a header is offered. The stream supplies exactly the announced number of payload bytes before the next header. Read data is valid in the cycle after the read request. The bench's memory model answers every read one cycle late from its own byte store. Its frame task offers one header, then exactly the announced count of bytes, and then waits for the header input to become ready again before it starts another frame. Stop and interrupt enable change only between frames.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE,
    ST_EXAM,
    ST_LEN_HI,
    ST_LEN_LO,
    ST_COPY,
    ST_CLOSE,
    ST_FLUSH
  } rxr_state_e;

  typedef enum logic [1:0] {
    AK_STAT,
    AK_MLEN0,
    AK_MLEN1,
    AK_DATA
  } rxr_akind_e;

  localparam logic [7:0] OWN_ONLY  = 8'h80;
  localparam logic [7:0] DONE_PAT  = 8'h03;
  localparam int         CRC_ALLOW = 4;

endpackage

// File: rtl/rxr_lenfmt.sv
module rxr_lenfmt
  import rxr_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int BUF_BYTES = 1544,
  parameter bit SWAP_MLEN = 1'b1
) (
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] store_cnt_o,
  output logic [7:0]       mlen_b0_o,
  output logic [7:0]       mlen_b1_o
);

  localparam logic [LEN_W-1:0] SLOT_MAX = LEN_W'(BUF_BYTES);

  logic [15:0] mlen;

  always_comb begin
    store_cnt_o = (len_i > SLOT_MAX) ? SLOT_MAX : len_i;
    mlen        = 16'(store_cnt_o) + 16'(CRC_ALLOW);
  end

  generate
    if (SWAP_MLEN) begin : g_swapped
      assign mlen_b0_o = mlen[15:8];
      assign mlen_b1_o = mlen[7:0];
    end else begin : g_native
      assign mlen_b0_o = mlen[7:0];
      assign mlen_b1_o = mlen[15:8];
    end
  endgenerate

endmodule

// File: rtl/rxr_addr.sv
module rxr_addr
  import rxr_pkg::*;
#(
  parameter int RING_LOG    = 4,
  parameter int ADDR_W      = 24,
  parameter int LEN_W       = 11,
  parameter int BUF_BYTES   = 1544,
  parameter int DESC_STRIDE = 8,
  parameter int STAT_OFS    = 2,
  parameter int MLEN_OFS    = 6
) (
  input  logic [ADDR_W-1:0]   desc_base_i,
  input  logic [ADDR_W-1:0]   buf_base_i,
  input  logic [RING_LOG-1:0] idx_i,
  input  logic [LEN_W-1:0]    cnt_i,
  input  rxr_akind_e          kind_i,
  output logic [ADDR_W-1:0]   addr_o
);

  logic [ADDR_W-1:0] desc_addr;
  logic [ADDR_W-1:0] slot_addr;

  always_comb begin
    desc_addr = desc_base_i + ADDR_W'(idx_i) * ADDR_W'(DESC_STRIDE);
    slot_addr = buf_base_i + ADDR_W'(idx_i) * ADDR_W'(BUF_BYTES);
    unique case (kind_i)
      AK_STAT:  addr_o = desc_addr + ADDR_W'(STAT_OFS);
      AK_MLEN0: addr_o = desc_addr + ADDR_W'(MLEN_OFS);
      AK_MLEN1: addr_o = desc_addr + ADDR_W'(MLEN_OFS + 1);
      default:  addr_o = slot_addr + ADDR_W'(cnt_i);
    endcase
  end

endmodule

// File: rtl/rxr_fsm.sv
module rxr_fsm
  import rxr_pkg::*;
#(
  parameter int RING_LOG  = 4,
  parameter int LEN_W     = 11,
  parameter int BUF_BYTES = 1544
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stop_i,
  input  logic                int_en_i,
  input  logic                hdr_valid_i,
  input  logic [LEN_W-1:0]    hdr_len_i,
  output logic                hdr_ready_o,
  input  logic                dat_valid_i,
  input  logic [7:0]          dat_byte_i,
  output logic                dat_ready_o,
  input  logic [7:0]          mem_rdata_i,
  input  logic [LEN_W-1:0]    store_cnt_i,
  input  logic [7:0]          mlen_b0_i,
  input  logic [7:0]          mlen_b1_i,
  output logic [LEN_W-1:0]    len_o,
  output logic [LEN_W-1:0]    cnt_o,
  output logic [RING_LOG-1:0] idx_o,
  output rxr_akind_e          kind_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [7:0]          mem_wdata_o,
  output logic [RING_LOG-1:0] ptr_o,
  output logic                done_o,
  output logic                irq_o,
  output logic                drop_o
);

  localparam int                 RING_N   = 1 << RING_LOG;
  localparam logic [RING_LOG-1:0] LAST_TRY = RING_LOG'(RING_N - 2);
  localparam logic [LEN_W-1:0]    SLOT_MAX = LEN_W'(BUF_BYTES);

  rxr_state_e          state_q, state_d;
  logic [RING_LOG-1:0] ptr_q, ptr_d;
  logic [RING_LOG-1:0] idx_q, idx_d;
  logic [RING_LOG-1:0] tries_q, tries_d;
  logic [LEN_W-1:0]    len_q, len_d;
  logic [LEN_W-1:0]    cnt_q, cnt_d;
  logic                last_byte;
  logic                owned;

  assign last_byte = (cnt_q == LEN_W'(len_q - LEN_W'(1)));
  assign owned     = (mem_rdata_i == OWN_ONLY);

  always_comb begin
    state_d     = state_q;
    ptr_d       = ptr_q;
    idx_d       = idx_q;
    tries_d     = tries_q;
    len_d       = len_q;
    cnt_d       = cnt_q;
    hdr_ready_o = 1'b0;
    dat_ready_o = 1'b0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_wdata_o = 8'h00;
    kind_o      = AK_STAT;
    done_o      = 1'b0;
    irq_o       = 1'b0;
    drop_o      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        hdr_ready_o = 1'b1;
        if (hdr_valid_i) begin
          len_d   = hdr_len_i;
          cnt_d   = '0;
          idx_d   = ptr_q;
          tries_d = '0;
          if (!stop_i)                 state_d = ST_PROBE;
          else if (hdr_len_i != '0)    state_d = ST_FLUSH;
        end
      end
      ST_PROBE: begin
        mem_req_o = 1'b1;
        kind_o    = AK_STAT;
        state_d   = ST_EXAM;
      end
      ST_EXAM: begin
        if (owned) begin
          state_d = ST_LEN_HI;
        end else if (tries_q == LAST_TRY) begin
          drop_o  = 1'b1;
          state_d = (len_q == '0) ? ST_IDLE : ST_FLUSH;
        end else begin
          idx_d   = idx_q + 1'b1;
          tries_d = tries_q + 1'b1;
          state_d = ST_PROBE;
        end
      end
      ST_LEN_HI: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        kind_o      = AK_MLEN0;
        mem_wdata_o = mlen_b0_i;
        state_d     = ST_LEN_LO;
      end
      ST_LEN_LO: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        kind_o      = AK_MLEN1;
        mem_wdata_o = mlen_b1_i;
        state_d     = (len_q == '0) ? ST_CLOSE : ST_COPY;
      end
      ST_COPY: begin
        dat_ready_o = 1'b1;
        kind_o      = AK_DATA;
        mem_wdata_o = dat_byte_i;
        if (dat_valid_i) begin
          mem_req_o = (cnt_q < store_cnt_i);
          mem_we_o  = (cnt_q < store_cnt_i);
          cnt_d     = cnt_q + 1'b1;
          if (last_byte) state_d = ST_CLOSE;
        end
      end
      ST_CLOSE: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        kind_o      = AK_STAT;
        mem_wdata_o = DONE_PAT;
        done_o      = 1'b1;
        irq_o       = int_en_i;
        ptr_d       = ptr_q + 1'b1;
        state_d     = ST_IDLE;
      end
      ST_FLUSH: begin
        dat_ready_o = 1'b1;
        if (dat_valid_i) begin
          cnt_d = cnt_q + 1'b1;
          if (last_byte) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      idx_q   <= '0;
      tries_q <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      idx_q   <= idx_d;
      tries_q <= tries_d;
      len_q   <= len_d;
      cnt_q   <= cnt_d;
    end
  end

  assign len_o = len_q;
  assign cnt_o = cnt_q;
  assign idx_o = idx_q;
  assign ptr_o = ptr_q;

  // R2: a descriptor is claimed only right after its status read returned 0x80
  a_r2_claim_after_own: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LEN_HI) |-> $past((state_q == ST_EXAM) && (mem_rdata_i == OWN_ONLY)));

  // R3: never more than 15 probes per frame
  a_r3_probe_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROBE) |-> (tries_q <= LAST_TRY));

  // R6: no payload write beyond the slot size
  a_r6_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && (kind_o == AK_DATA)) |-> (cnt_q < SLOT_MAX));

  // R8: pointer steps by one on completion
  a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CLOSE) |=> (ptr_q == RING_LOG'($past(ptr_q) + 1'b1)));

  // R8: pointer holds otherwise
  a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_CLOSE) |=> $stable(ptr_q));

  // R10: a frame accepted while stopped makes no memory access
  a_r10_stop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_ready_o && hdr_valid_i && stop_i) |=> !mem_req_o);

endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxr_pkg::*;
#(
  parameter int RING_LOG    = 4,
  parameter int ADDR_W      = 24,
  parameter int LEN_W       = 11,
  parameter int BUF_BYTES   = 1544,
  parameter int DESC_STRIDE = 8,
  parameter int STAT_OFS    = 2,
  parameter int MLEN_OFS    = 6,
  parameter bit SWAP_MLEN   = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stop_i,
  input  logic                int_en_i,
  input  logic [ADDR_W-1:0]   desc_base_i,
  input  logic [ADDR_W-1:0]   buf_base_i,
  input  logic                hdr_valid_i,
  input  logic [LEN_W-1:0]    hdr_len_i,
  output logic                hdr_ready_o,
  input  logic                dat_valid_i,
  input  logic [7:0]          dat_byte_i,
  output logic                dat_ready_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [7:0]          mem_wdata_o,
  input  logic [7:0]          mem_rdata_i,
  output logic [RING_LOG-1:0] ring_ptr_o,
  output logic                rx_done_o,
  output logic                irq_o,
  output logic                drop_o
);

  logic [LEN_W-1:0]    len_w;
  logic [LEN_W-1:0]    cnt_w;
  logic [LEN_W-1:0]    store_cnt_w;
  logic [RING_LOG-1:0] idx_w;
  logic [7:0]          mlen_b0_w;
  logic [7:0]          mlen_b1_w;
  rxr_akind_e          kind_w;

  rxr_fsm #(
    .RING_LOG  (RING_LOG),
    .LEN_W     (LEN_W),
    .BUF_BYTES (BUF_BYTES)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_i      (stop_i),
    .int_en_i    (int_en_i),
    .hdr_valid_i (hdr_valid_i),
    .hdr_len_i   (hdr_len_i),
    .hdr_ready_o (hdr_ready_o),
    .dat_valid_i (dat_valid_i),
    .dat_byte_i  (dat_byte_i),
    .dat_ready_o (dat_ready_o),
    .mem_rdata_i (mem_rdata_i),
    .store_cnt_i (store_cnt_w),
    .mlen_b0_i   (mlen_b0_w),
    .mlen_b1_i   (mlen_b1_w),
    .len_o       (len_w),
    .cnt_o       (cnt_w),
    .idx_o       (idx_w),
    .kind_o      (kind_w),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .ptr_o       (ring_ptr_o),
    .done_o      (rx_done_o),
    .irq_o       (irq_o),
    .drop_o      (drop_o)
  );

  rxr_lenfmt #(
    .LEN_W     (LEN_W),
    .BUF_BYTES (BUF_BYTES),
    .SWAP_MLEN (SWAP_MLEN)
  ) u_lenfmt (
    .len_i       (len_w),
    .store_cnt_o (store_cnt_w),
    .mlen_b0_o   (mlen_b0_w),
    .mlen_b1_o   (mlen_b1_w)
  );

  rxr_addr #(
    .RING_LOG    (RING_LOG),
    .ADDR_W      (ADDR_W),
    .LEN_W       (LEN_W),
    .BUF_BYTES   (BUF_BYTES),
    .DESC_STRIDE (DESC_STRIDE),
    .STAT_OFS    (STAT_OFS),
    .MLEN_OFS    (MLEN_OFS)
  ) u_addr (
    .desc_base_i (desc_base_i),
    .buf_base_i  (buf_base_i),
    .idx_i       (idx_w),
    .cnt_i       (cnt_w),
    .kind_i      (kind_w),
    .addr_o      (mem_addr_o)
  );

endmodule

// File: tb/rxring_writer_bench.sv
module rxring_writer_bench;

  localparam int DESC = 'h100;
  localparam int BUFB = 'h1000;
  localparam int SLOT = 1544;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stop_i = 1'b0;
  logic        int_en_i = 1'b0;
  logic [23:0] desc_base_i = 24'(DESC);
  logic [23:0] buf_base_i = 24'(BUFB);
  logic        hdr_valid_i = 1'b0;
  logic [10:0] hdr_len_i = '0;
  logic        hdr_ready_o;
  logic        dat_valid_i = 1'b0;
  logic [7:0]  dat_byte_i = '0;
  logic        dat_ready_o;
  logic        mem_req_o, mem_we_o;
  logic [23:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;
  logic [3:0]  ring_ptr_o;
  logic        rx_done_o, irq_o, drop_o;

  always #2 clk = ~clk;

  rxring_writer u_rxring_writer (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .int_en_i(int_en_i),
    .desc_base_i(desc_base_i), .buf_base_i(buf_base_i),
    .hdr_valid_i(hdr_valid_i), .hdr_len_i(hdr_len_i), .hdr_ready_o(hdr_ready_o),
    .dat_valid_i(dat_valid_i), .dat_byte_i(dat_byte_i), .dat_ready_o(dat_ready_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .ring_ptr_o(ring_ptr_o), .rx_done_o(rx_done_o), .irq_o(irq_o), .drop_o(drop_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] mem [int];
  int exp_q [$];
  int rd_cnt = 0, done_cnt = 0, irq_cnt = 0, drop_cnt = 0;
  int model_ptr = 0;

  function automatic logic [7:0] rd(int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // memory model: one cycle read latency
  always @(posedge clk) if (mem_req_o && !mem_we_o) mem_rdata_i <= rd(int'(mem_addr_o));

  // per-clock comparison of every memory write against the model's queue
  always @(negedge clk) if (rst_n) begin
    if (mem_req_o && !mem_we_o) rd_cnt++;
    if (rx_done_o) done_cnt++;
    if (irq_o) irq_cnt++;
    if (drop_o) drop_cnt++;
    if (mem_req_o && mem_we_o) begin
      if (exp_q.size() == 0) begin
        chk(0, "R10/R11", "unexpected write addr", int'(mem_addr_o), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(mem_addr_o) == (e >> 8), "R4/R5/R7", "write addr", int'(mem_addr_o), e >> 8);
        chk(int'(mem_wdata_o) == (e & 255), "R4/R5/R7", "write data", int'(mem_wdata_o), e & 255);
      end
      mem[int'(mem_addr_o)] = mem_wdata_o;
    end
  end

  task automatic push_w(int a, int d);
    exp_q.push_back((a << 8) | (d & 255));
  endtask

  task automatic send(int len, int seed, string req);
    int e_reads, e_done, e_irq, e_drop, slot, stored, m;
    int r0, d0, i0, p0;
    e_reads = 0; e_done = 0; e_irq = 0; e_drop = 0; slot = -1;
    if (!stop_i) begin
      for (int k = 0; k < 15; k++) begin
        int i;
        i = (model_ptr + k) % 16;
        e_reads++;
        if (rd(DESC + 8*i + 2) == 8'h80) begin slot = i; break; end
      end
      if (slot < 0) e_drop = 1;
      else begin
        stored = (len > SLOT) ? SLOT : len;
        m = stored + 4;
        push_w(DESC + 8*slot + 6, m >> 8);
        push_w(DESC + 8*slot + 7, m & 255);
        for (int b = 0; b < stored; b++) push_w(BUFB + SLOT*slot + b, seed + b);
        push_w(DESC + 8*slot + 2, 3);
        model_ptr = (model_ptr + 1) % 16;
        e_done = 1;
        e_irq = int_en_i ? 1 : 0;
      end
    end
    r0 = rd_cnt; d0 = done_cnt; i0 = irq_cnt; p0 = drop_cnt;
    @(negedge clk);
    hdr_valid_i = 1'b1; hdr_len_i = 11'(len);
    while (!hdr_ready_o) @(negedge clk);
    @(posedge clk); @(negedge clk);
    hdr_valid_i = 1'b0;
    for (int b = 0; b < len; b++) begin
      dat_valid_i = 1'b1; dat_byte_i = 8'(seed + b);
      while (!dat_ready_o) @(negedge clk);
      @(posedge clk); @(negedge clk);
    end
    dat_valid_i = 1'b0;
    while (!hdr_ready_o) @(negedge clk);
    chk(exp_q.size() == 0, req, "missing writes", exp_q.size(), 0);
    exp_q.delete();
    chk(rd_cnt - r0 == e_reads, "R3", "status reads", rd_cnt - r0, e_reads);
    chk(done_cnt - d0 == e_done, "R9", "done pulses", done_cnt - d0, e_done);
    chk(irq_cnt - i0 == e_irq, "R9", "irq pulses", irq_cnt - i0, e_irq);
    chk(drop_cnt - p0 == e_drop, "R11", "drop pulses", drop_cnt - p0, e_drop);
    chk(int'(ring_ptr_o) == model_ptr, "R8", "ring pointer", int'(ring_ptr_o), model_ptr);
  endtask

  task automatic set_stat(int i, int v);
    mem[DESC + 8*i + 2] = 8'(v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(0, "ALL", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ring_ptr_o == 0, "R1", "pointer", int'(ring_ptr_o), 0);
    chk(!mem_req_o, "R1", "mem_req", int'(mem_req_o), 0);
    chk(hdr_ready_o, "R1", "hdr_ready", int'(hdr_ready_o), 1);
    chk(!rx_done_o && !irq_o && !drop_o, "R1", "pulses", int'(rx_done_o | irq_o | drop_o), 0);

    // R10 stopped: no access at all
    for (int i = 0; i < 16; i++) set_stat(i, 0);
    set_stat(0, 'h80);
    stop_i = 1'b1; int_en_i = 1'b1;
    send(10, 'h20, "R10");
    stop_i = 1'b0;

    // R4 R5 R7 R9 basic store with interrupt
    send(5, 'h10, "R5");
    chk(rd(DESC + 2) == 8'h03, "R7", "status after store", int'(rd(DESC + 2)), 3);

    // R9 interrupt disabled
    int_en_i = 1'b0;
    set_stat(1, 'h80);
    send(60, 'h40, "R9");
    int_en_i = 1'b1;

    // R2 exact match required, R8 pointer steps by one only
    set_stat(2, 'h00); set_stat(3, 'h81); set_stat(4, 'h80);
    send(7, 'h55, "R2");
    chk(rd(DESC + 8*3 + 2) == 8'h81, "R2", "skipped entry untouched", int'(rd(DESC + 26)), 'h81);

    // R11 and R3: only entry ptr-1 is usable, it must not be probed
    for (int i = 0; i < 16; i++) set_stat(i, 0);
    set_stat(2, 'h80);
    send(9, 'h70, "R11");

    // R12 zero-length frame
    set_stat(3, 'h80);
    send(0, 0, "R12");

    // R6 truncation
    set_stat(4, 'h80);
    send(1600, 'h33, "R6");

    // advance pointer to 15
    for (int p = 5; p < 15; p++) begin
      set_stat(p, 'h80);
      send(1, p, "R8");
    end

    // R3 wrap: entry 15 not owned, entry 0 owned
    set_stat(15, 'h00); set_stat(0, 'h80);
    send(3, 'h90, "R3");
    chk(rd(DESC + 2) == 8'h03, "R3", "wrapped entry completed", int'(rd(DESC + 2)), 3);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule